// File: doc/BRIEF.md
# Serial EEPROM Command Sequencer

This block is the command layer of a serial EEPROM slave holding 4096 or 8192 bytes. A serial front end has already turned the bit stream into whole bytes. It hands them over one at a time, together with pulses that mark the start and the end of a chip-select window. The sequencer reads the first byte of each window as an opcode and runs the command it names. The commands set or clear the write-enable latch, return the status byte, stream bytes out of storage, load a new status value, or collect a page of data for programming.

Programming is deferred. Data bytes are gathered in a page-sized holding buffer, and nothing reaches storage until the select window closes on a whole byte. The commit then sets a busy flag for a fixed number of clock cycles. During the first cycles of that period, each buffered byte is written through a simple synchronous storage port. Before each byte is written, the address is presented to an external protection unit, which may veto the write. While busy, the block accepts only a status read. At the end of the busy period the write-enable latch clears itself.

Top module: `eeprom_cmd_seq`

## Requirements
- R1: After reset the busy flag and the write-enable latch are clear and SO is not driven, so a status read returns zero in bits 1:0.
- R2: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. The latch is visible as bit 1 of the status byte.
- R3: After opcode 0x05, SO is driven for the rest of the window and the output byte is {protFlags[5:0], latch, busy}, with busy in bit 0.
- R4: Opcode 0x03 is followed by a 16-bit address, high byte first. Data then streams from that address, and each further byte clocked through advances the address by one.
- R5: A stream that passes address DEPTH-1 continues at address 0. Address bits at or above log2(DEPTH) are ignored.
- R6: Opcodes 0x02 and 0x01 received while the latch is clear are ignored until the next select; storage and status stay unchanged.
- R7: Opcode 0x02 is followed by a 16-bit address and data bytes. Each data byte advances only the low log2(PAGE) address bits, so the bytes stay inside one page.
- R8: When a window carries more than PAGE data bytes, the later bytes wrap to the page start and replace the earlier ones.
- R9: A write is committed only when the window ends with no partial byte and at least one data byte received; otherwise it is dropped, no busy period starts and the latch keeps its value.
- R10: A commit raises status bit 0 for exactly WRITE_CYCLES cycles. Storage writes happen only in that period, and every opcode other than 0x05 received during it is ignored.
- R11: The write-enable latch clears when the busy period ends.
- R12: An unrecognised opcode leaves SO undriven and makes the rest of the window have no effect.
- R13: During a page commit, a byte whose address the protection unit flags as blocked is not written.
- R14: Opcode 0x01 with the latch set captures one data byte. When the window closes it emits a one-cycle status-write strobe with that byte and starts a busy period, unless the status lock input is high at that moment, in which case it is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| selStart | input | 1 | One-cycle pulse: chip select asserted |
| selEnd | input | 1 | One-cycle pulse: chip select released |
| partialByte | input | 1 | Valid with selEnd: the window ended with an incomplete byte |
| byteValid | input | 1 | One-cycle pulse: rxByte holds a complete received byte |
| rxByte | input | 8 | Received byte |
| soEnable | output | 1 | Front end should drive SO; otherwise it is high impedance |
| txByte | output | 8 | Byte for the front end to shift out next |
| memAddr | output | log2(DEPTH) | Storage address |
| memRe | output | 1 | Storage read request; data is returned one cycle later |
| memWe | output | 1 | Storage write strobe |
| memWrData | output | 8 | Storage write data |
| memRdData | input | 8 | Storage read data |
| protAddr | output | log2(DEPTH) | Address being tested by the protection unit |
| protBlocked | input | 1 | Protection unit: protAddr must not be written |
| protFlags | input | 6 | Upper six status bits supplied by the protection unit |
| srLocked | input | 1 | Status writes are locked by hardware |
| srWrEn | output | 1 | One-cycle strobe: load a new status value |
| srWrData | output | 8 | Status value to load |

## Verification
The bench builds the block with DEPTH 256, PAGE 32 and WRITE_CYCLES 48. The small depth puts the end of the address range within a few bytes of the start, so the read wrap and the ignored upper address bits are tested on a short stream. With a busy period only slightly longer than the page, the commit sweep, the rejection of commands while busy, and the automatic clearing of the latch all happen within a few hundred cycles. A protection limit inside one page makes a single write land partly in allowed and partly in blocked addresses.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    S_OPC, S_ADDR_HI, S_ADDR_LO, S_RD_DATA,
    S_WR_DATA, S_SR_DATA, S_SR_OUT, S_IGNORE
  } cmdState_e;

  typedef enum logic [1:0] { K_NONE, K_PAGE, K_STATUS } wrKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic addrHi;
    logic addrLo;
    logic rdAdvance;
    logic rdFetch;
    logic bufClear;
    logic bufWrite;
    logic srCapture;
    logic commitRun;
  } dpStrobe_t;

endpackage

// File: rtl/eeprom_seq_ctrl.sv
module eeprom_seq_ctrl
  import eeprom_seq_pkg::*;
#(
  parameter int PAGE         = 32,
  parameter int WRITE_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       selStart,
  input  logic       selEnd,
  input  logic       partialByte,
  input  logic       byteValid,
  input  logic [7:0] rxByte,
  input  logic       srLocked,
  output dpStrobe_t  strobe,
  output logic       busy,
  output logic       wel,
  output logic       soEnable,
  output logic       txIsStatus,
  output logic       srWrEn
);

  localparam int CNT_W = $clog2(WRITE_CYCLES);

  cmdState_e        state;
  wrKind_e          wrKind;
  wrKind_e          pendKind;
  logic [CNT_W-1:0] cnt;
  logic             isWrite;
  logic             hasData;
  logic             fetchReq;
  logic             fetchNext;
  logic             byteEvt;
  logic             commitOk;

  assign byteEvt = byteValid && !selStart && !selEnd;

  always_comb begin
    strobe    = '0;
    fetchNext = 1'b0;
    if (byteEvt) begin
      case (state)
        S_OPC:     strobe.bufClear = !busy && wel && (rxByte == OP_WRITE);
        S_ADDR_HI: strobe.addrHi = 1'b1;
        S_ADDR_LO: begin
          strobe.addrLo = 1'b1;
          fetchNext     = !isWrite;
        end
        S_RD_DATA: begin
          strobe.rdAdvance = 1'b1;
          fetchNext        = 1'b1;
        end
        S_WR_DATA: strobe.bufWrite = 1'b1;
        S_SR_DATA: strobe.srCapture = !hasData;
        default: ;
      endcase
    end
    strobe.rdFetch   = fetchReq;
    strobe.commitRun = busy && (wrKind == K_PAGE) && (cnt < CNT_W'(PAGE));
  end

  always_comb begin
    case (state)
      S_WR_DATA: pendKind = K_PAGE;
      S_SR_DATA: pendKind = K_STATUS;
      default:   pendKind = K_NONE;
    endcase
    commitOk = !busy && (pendKind != K_NONE) && !partialByte && hasData &&
               !((pendKind == K_STATUS) && srLocked);
  end

  assign soEnable   = (state == S_SR_OUT) || (state == S_RD_DATA);
  assign txIsStatus = (state == S_SR_OUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IGNORE;
      wrKind   <= K_NONE;
      cnt      <= '0;
      busy     <= 1'b0;
      wel      <= 1'b0;
      isWrite  <= 1'b0;
      hasData  <= 1'b0;
      fetchReq <= 1'b0;
      srWrEn   <= 1'b0;
    end else begin
      fetchReq <= fetchNext;
      srWrEn   <= 1'b0;
      if (busy) begin
        if (cnt == CNT_W'(WRITE_CYCLES - 1)) begin
          busy   <= 1'b0;
          wel    <= 1'b0;
          cnt    <= '0;
          wrKind <= K_NONE;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
      if (selStart) begin
        state   <= S_OPC;
        hasData <= 1'b0;
      end else if (selEnd) begin
        state <= S_IGNORE;
        if (commitOk) begin
          busy   <= 1'b1;
          cnt    <= '0;
          wrKind <= pendKind;
          srWrEn <= (pendKind == K_STATUS);
        end
      end else if (byteValid) begin
        case (state)
          S_OPC: begin
            if (busy) begin
              state <= (rxByte == OP_RDSR) ? S_SR_OUT : S_IGNORE;
            end else begin
              case (rxByte)
                OP_WREN:  begin wel <= 1'b1; state <= S_IGNORE; end
                OP_WRDI:  begin wel <= 1'b0; state <= S_IGNORE; end
                OP_RDSR:  state <= S_SR_OUT;
                OP_WRSR:  state <= wel ? S_SR_DATA : S_IGNORE;
                OP_READ:  begin isWrite <= 1'b0; state <= S_ADDR_HI; end
                OP_WRITE: begin
                  isWrite <= 1'b1;
                  state   <= wel ? S_ADDR_HI : S_IGNORE;
                end
                default:  state <= S_IGNORE;
              endcase
            end
          end
          S_ADDR_HI: state <= S_ADDR_LO;
          S_ADDR_LO: state <= isWrite ? S_WR_DATA : S_RD_DATA;
          S_WR_DATA: hasData <= 1'b1;
          S_SR_DATA: hasData <= 1'b1;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/eeprom_seq_datapath.sv
module eeprom_seq_datapath
  import eeprom_seq_pkg::*;
#(
  parameter int DEPTH = 4096,
  parameter int PAGE  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  dpStrobe_t                strobe,
  input  logic [7:0]               rxByte,
  input  logic [7:0]               memRdData,
  input  logic                     protBlocked,
  output logic [$clog2(DEPTH)-1:0] memAddr,
  output logic                     memRe,
  output logic                     memWe,
  output logic [7:0]               memWrData,
  output logic [$clog2(DEPTH)-1:0] protAddr,
  output logic [7:0]               txData,
  output logic [7:0]               srData
);

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PAGE_W = $clog2(PAGE);
  localparam int BASE_W = ADDR_W - PAGE_W;

  logic [15:0]        addrReg;
  logic [ADDR_W-1:0]  addrEff;
  logic [ADDR_W-1:0]  nextRd;
  logic [BASE_W-1:0]  pageBase;
  logic [PAGE_W-1:0]  wrOff;
  logic [PAGE_W-1:0]  commitIdx;
  logic [ADDR_W-1:0]  commitAddr;
  logic               rdPending;
  logic               slotValid [PAGE];
  logic [7:0]         slotData  [PAGE];

  assign addrEff    = addrReg[ADDR_W-1:0];
  assign nextRd     = addrEff + ADDR_W'(1);
  assign pageBase   = addrEff[ADDR_W-1:PAGE_W];
  assign commitAddr = {pageBase, commitIdx};

  assign memAddr   = strobe.commitRun ? commitAddr : addrEff;
  assign memRe     = strobe.rdFetch;
  assign protAddr  = commitAddr;
  assign memWe     = strobe.commitRun && slotValid[commitIdx] && !protBlocked;
  assign memWrData = slotData[commitIdx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrReg   <= '0;
      wrOff     <= '0;
      commitIdx <= '0;
      rdPending <= 1'b0;
      txData    <= '0;
      srData    <= '0;
    end else begin
      rdPending <= strobe.rdFetch;
      if (rdPending) txData <= memRdData;
      if (strobe.addrHi) addrReg[15:8] <= rxByte;
      if (strobe.addrLo) begin
        addrReg[7:0] <= rxByte;
        wrOff        <= rxByte[PAGE_W-1:0];
      end
      if (strobe.rdAdvance) addrReg <= {{(16 - ADDR_W){1'b0}}, nextRd};
      if (strobe.bufWrite)  wrOff   <= wrOff + PAGE_W'(1);
      if (strobe.bufClear)  commitIdx <= '0;
      else if (strobe.commitRun) commitIdx <= commitIdx + PAGE_W'(1);
      if (strobe.srCapture) srData <= rxByte;
    end
  end

  for (genvar i = 0; i < PAGE; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slotValid[i] <= 1'b0;
      else if (strobe.bufClear)
        slotValid[i] <= 1'b0;
      else if (strobe.bufWrite && (wrOff == PAGE_W'(i)))
        slotValid[i] <= 1'b1;
    end
    always_ff @(posedge clk) begin
      if (strobe.bufWrite && (wrOff == PAGE_W'(i)))
        slotData[i] <= rxByte;
    end
  end

endmodule

// File: rtl/eeprom_cmd_seq.sv
module eeprom_cmd_seq
  import eeprom_seq_pkg::*;
#(
  parameter int DEPTH        = 4096,
  parameter int PAGE         = 32,
  parameter int WRITE_CYCLES = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     selStart,
  input  logic                     selEnd,
  input  logic                     partialByte,
  input  logic                     byteValid,
  input  logic [7:0]               rxByte,
  output logic                     soEnable,
  output logic [7:0]               txByte,
  output logic [$clog2(DEPTH)-1:0] memAddr,
  output logic                     memRe,
  output logic                     memWe,
  output logic [7:0]               memWrData,
  input  logic [7:0]               memRdData,
  output logic [$clog2(DEPTH)-1:0] protAddr,
  input  logic                     protBlocked,
  input  logic [5:0]               protFlags,
  input  logic                     srLocked,
  output logic                     srWrEn,
  output logic [7:0]               srWrData
);

  dpStrobe_t  strobe;
  logic       busy;
  logic       wel;
  logic       txIsStatus;
  logic [7:0] txData;

  eeprom_seq_ctrl #(.PAGE(PAGE), .WRITE_CYCLES(WRITE_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .selStart(selStart), .selEnd(selEnd),
    .partialByte(partialByte), .byteValid(byteValid), .rxByte(rxByte),
    .srLocked(srLocked), .strobe(strobe), .busy(busy), .wel(wel),
    .soEnable(soEnable), .txIsStatus(txIsStatus), .srWrEn(srWrEn)
  );

  eeprom_seq_datapath #(.DEPTH(DEPTH), .PAGE(PAGE)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rxByte(rxByte),
    .memRdData(memRdData), .protBlocked(protBlocked), .memAddr(memAddr),
    .memRe(memRe), .memWe(memWe), .memWrData(memWrData),
    .protAddr(protAddr), .txData(txData), .srData(srWrData)
  );

  assign txByte = txIsStatus ? {protFlags, wel, busy} : txData;

endmodule

// File: rtl/eeprom_cmd_seq_chk.sv
module eeprom_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       wel,
  input logic       memWe,
  input logic       protBlocked,
  input logic       selStart,
  input logic       selEnd,
  input logic       srWrEn,
  input logic       byteValid,
  input logic [7:0] rxByte,
  input logic       soEnable
);

  assert_store_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    memWe |-> busy);

  assert_blocked_skip_R13: assert property (@(posedge clk) disable iff (!rst_n)
    memWe |-> !protBlocked);

  assert_latch_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);

  assert_commit_on_close_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(selEnd));

  assert_latch_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> ($past(byteValid) && ($past(rxByte) == 8'h06)));

  assert_status_strobe_R14: assert property (@(posedge clk) disable iff (!rst_n)
    srWrEn |-> (busy && wel));

  assert_quiet_after_select_R12: assert property (@(posedge clk) disable iff (!rst_n)
    selStart |=> !soEnable);

endmodule

bind eeprom_cmd_seq eeprom_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wel(wel), .memWe(memWe),
  .protBlocked(protBlocked), .selStart(selStart), .selEnd(selEnd),
  .srWrEn(srWrEn), .byteValid(byteValid), .rxByte(rxByte),
  .soEnable(soEnable)
);

// File: tb/sim_eeprom_cmd_seq.sv
`timescale 1ns/1ps
module sim_eeprom_cmd_seq;

  localparam int DEPTH = 256;
  localparam int PAGE  = 32;
  localparam int WC    = 48;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          selStart = 1'b0, selEnd = 1'b0, partialByte = 1'b0;
  logic          byteValid = 1'b0;
  logic [7:0]    rxByte = '0;
  logic          soEnable;
  logic [7:0]    txByte;
  logic [AW-1:0] memAddr, protAddr;
  logic          memRe, memWe, protBlocked, srWrEn;
  logic [7:0]    memWrData, srWrData;
  logic [7:0]    memRdData = '0;
  logic [5:0]    protFlags = 6'h2A;
  logic          srLocked = 1'b0;

  int nChk = 0, nErr = 0, soMiss = 0, srCount = 0, protLimit = DEPTH;
  logic [7:0] srLast = '0;
  logic [7:0] memArr [DEPTH];
  logic [7:0] refMem [DEPTH];
  bit expSo = 0, welM = 0, done = 0;

  always #2.5 clk = ~clk;

  eeprom_cmd_seq #(.DEPTH(DEPTH), .PAGE(PAGE), .WRITE_CYCLES(WC)) u0 (
    .clk(clk), .rst_n(rst_n), .selStart(selStart), .selEnd(selEnd),
    .partialByte(partialByte), .byteValid(byteValid), .rxByte(rxByte),
    .soEnable(soEnable), .txByte(txByte), .memAddr(memAddr), .memRe(memRe),
    .memWe(memWe), .memWrData(memWrData), .memRdData(memRdData),
    .protAddr(protAddr), .protBlocked(protBlocked), .protFlags(protFlags),
    .srLocked(srLocked), .srWrEn(srWrEn), .srWrData(srWrData)
  );

  assign protBlocked = (int'(protAddr) >= protLimit);

  always @(posedge clk) begin
    if (memWe) memArr[memAddr] <= memWrData;
    if (memRe) memRdData <= memArr[memAddr];
    if (srWrEn) begin srCount++; srLast = srWrData; end
  end

  // per-cycle comparison of SO drive against the model
  always @(negedge clk) if (rst_n && (soEnable !== expSo)) soMiss++;

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic selectDev();
    selStart = 1'b1; tick(1); selStart = 1'b0; expSo = 0; tick(1);
  endtask

  task automatic sendByte(input int b, input bit so);
    rxByte = 8'(b); byteValid = 1'b1; tick(1); byteValid = 1'b0; expSo = so; tick(6);
  endtask

  task automatic deselect(input bit partial);
    partialByte = partial; selEnd = 1'b1; tick(1);
    selEnd = 1'b0; partialByte = 1'b0; expSo = 0; tick(2);
  endtask

  task automatic command(input int op);
    selectDev(); sendByte(op, 0); deselect(0);
  endtask

  task automatic readStatus(output int v);
    selectDev(); sendByte(8'h05, 1); v = int'(txByte); deselect(0);
  endtask

  task automatic readSeq(input string req, input int addr, input int n);
    selectDev(); sendByte(8'h03, 0); sendByte(addr >> 8, 0); sendByte(addr & 8'hFF, 1);
    for (int i = 0; i < n; i++) begin
      check(req, int'(txByte), int'(refMem[(addr + i) % DEPTH]));
      sendByte(8'h00, 1);
    end
    deselect(0);
  endtask

  // page write; model commits only with latch set, whole bytes and >=1 data byte
  task automatic pageWrite(input int addr, input int n, input int seed, input bit partial);
    int base, off;
    base = (addr % DEPTH) - (addr % PAGE);
    selectDev(); sendByte(8'h02, 0); sendByte(addr >> 8, 0); sendByte(addr & 8'hFF, 0);
    for (int k = 0; k < n; k++) sendByte((seed + k * 13) & 8'hFF, 0);
    deselect(partial);
    if (welM && n > 0 && !partial) begin
      for (int k = 0; k < n; k++) begin
        off = (addr % PAGE + k) % PAGE;
        if (base + off < protLimit) refMem[base + off] = 8'((seed + k * 13) & 8'hFF);
      end
    end
  endtask

  function automatic int statusExp(input bit w, input bit b);
    return {24'd0, protFlags, w, b};
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      nChk++; nErr++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  end

  initial begin
    int st;
    for (int i = 0; i < DEPTH; i++) begin
      memArr[i] = 8'((i * 7 + 3) & 8'hFF);
      refMem[i] = 8'((i * 7 + 3) & 8'hFF);
    end
    tick(4);
    check("R1 soEnable in reset", int'(soEnable), 0);
    check("R1 memWe in reset", int'(memWe), 0);
    rst_n = 1'b1; tick(2);
    readStatus(st); check("R1 status after reset", st, statusExp(0, 0));

    // R2 latch set and clear
    command(8'h06); welM = 1;
    readStatus(st); check("R2 latch set", st, statusExp(1, 0));
    command(8'h04); welM = 0;
    readStatus(st); check("R2 latch clear", st, statusExp(0, 0));

    // R3 status byte follows protection flags
    protFlags = 6'h15;
    readStatus(st); check("R3 status flags", st, statusExp(0, 0));
    protFlags = 6'h2A;

    // R4 streaming read, R5 wrap and ignored upper address bits
    readSeq("R4 stream", 8'h10, 5);
    readSeq("R5 wrap", 16'h12FE, 4);

    // R6 write with latch clear ignored
    pageWrite(8'h30, 3, 8'h91, 0);
    readStatus(st); check("R6 no busy", st, statusExp(0, 0));
    readSeq("R6 storage unchanged", 8'h30, 3);

    // R7 / R8 page wrap and overwrite
    command(8'h06); welM = 1;
    pageWrite(8'h45, 40, 8'h21, 0);
    readStatus(st); check("R10 busy during write", st, statusExp(1, 1));
    tick(WC); welM = 0;
    readStatus(st); check("R11 latch cleared at end", st, statusExp(0, 0));
    readSeq("R7 R8 page content", 8'h40, PAGE);
    readSeq("R7 next page untouched", 8'h60, 2);

    // R10 commands ignored while busy
    command(8'h06); welM = 1;
    pageWrite(8'h80, 2, 8'h5C, 0);
    selectDev(); sendByte(8'h03, 0); sendByte(8'h00, 0); sendByte(8'h90, 0);
    check("R10 read rejected while busy", int'(soEnable), 0);
    deselect(0);
    selectDev(); sendByte(8'h02, 0); sendByte(8'h00, 0); sendByte(8'h88, 0);
    sendByte(8'hEE, 0); deselect(0);
    tick(WC); welM = 0;
    readSeq("R10 committed bytes", 8'h80, 2);
    readSeq("R10 busy write dropped", 8'h88, 1);

    // R9 discarded writes
    command(8'h06); welM = 1;
    pageWrite(8'h60, 2, 8'h77, 1);
    readStatus(st); check("R9 partial byte no busy", st, statusExp(1, 0));
    pageWrite(8'h60, 0, 8'h00, 0);
    readStatus(st); check("R9 no data no busy", st, statusExp(1, 0));
    command(8'h04); welM = 0;
    readSeq("R9 storage unchanged", 8'h60, 2);

    // R12 unknown opcode
    selectDev(); sendByte(8'hAB, 0);
    check("R12 SO undriven", int'(soEnable), 0);
    sendByte(8'h06, 0); sendByte(8'h05, 0);
    check("R12 later bytes ignored", int'(soEnable), 0);
    deselect(0);
    readStatus(st); check("R12 latch untouched", st, statusExp(0, 0));

    // R13 protection veto within one page
    protLimit = 8'hB0;
    command(8'h06); welM = 1;
    pageWrite(8'hAC, 20, 8'h33, 0);
    tick(WC); welM = 0;
    readSeq("R13 partial protection", 8'hA0, PAGE);
    protLimit = DEPTH;

    // R14 status write, then locked
    command(8'h06); welM = 1;
    selectDev(); sendByte(8'h01, 0); sendByte(8'h8C, 0); deselect(0);
    check("R14 strobe count", srCount, 1);
    check("R14 strobe data", int'(srLast), 8'h8C);
    readStatus(st); check("R14 busy after status write", st, statusExp(1, 1));
    tick(WC); welM = 0;
    srLocked = 1'b1;
    command(8'h06); welM = 1;
    selectDev(); sendByte(8'h01, 0); sendByte(8'h0C, 0); deselect(0);
    check("R14 locked no strobe", srCount, 1);
    readStatus(st); check("R14 locked no busy", st, statusExp(1, 0));
    srLocked = 1'b0;
    command(8'h04); welM = 0;

    // R6 status write with latch clear
    selectDev(); sendByte(8'h01, 0); sendByte(8'h44, 0); deselect(0);
    check("R6 status write ignored", srCount, 1);

    check("R3 R12 SO drive per cycle", soMiss, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

endmodule